// File: doc/BRIEF.md
# Cluster Performance Monitor Counter Unit

This block is a performance monitor shared by the cores of a processor cluster. It holds a parameterised set of 32-bit event counters and one 64-bit cycle counter. Each event counter has its own event-code register. The code picks which event input line the counter samples, and one reserved code makes it count every clock. Software reaches everything through a single-cycle register port. Through it, software can turn the monitor on as a whole, enable single counters and their interrupts, preload and read counter values, and collect the overflow status, which is cleared in the same access that reads it.

Every per-counter bitmap uses one layout: event counter i sits at bit i and the cycle counter at bit 31. A level interrupt is raised while any counter whose interrupt is enabled has a pending overflow. Two read-only words report which common event codes the cluster supports. The control word reports the counter count and two identification bytes.

Top module: `clu_perf_mon`

## Requirements
- R1: In every bitmap (enable, interrupt enable, overflow), event counter i is bit i and the cycle counter is bit 31. Bits of counters that are not implemented (indices NUM_CNT to 30) read 0 and ignore writes, and a counter address 0x20+i with i >= NUM_CNT reads 0.
- R2: Control word (address 0x00) bit 0 is the global enable. While it is 0 no counter changes except by register writes.
- R3: Control word bits 15:11 read NUM_CNT, bits 23:16 read the ID parameter and bits 31:24 read the IMPL parameter. Writes to these bits, and to bits 10:3, have no effect, and bits 10:1 read 0.
- R4: Enable bits are set by writing ones to address 0x01 and cleared by writing ones to 0x02. Interrupt-enable bits are set through 0x03 and cleared through 0x04. Zero bits in such a write leave the state unchanged, and a read of either address of a pair returns the current bitmap.
- R5: An enabled event counter (global enable and its own bit both set) adds one on each clock edge where the event line selected by its code (type register at 0x40+i, bits 7:0) is high. Code 0x11 counts every cycle. A code at or above EVT_LINES, other than 0x11, counts nothing.
- R6: An event counter advancing from 0xFFFFFFFF wraps to 0 and sets its overflow bit.
- R7: The cycle counter is 64 bits wide, read and written as a low word (0x08) and a high word (0x09). It adds one per cycle while global enable and bit 31 are set, and a wrap of all 64 bits sets overflow bit 31.
- R8: A read of address 0x05 returns the overflow bitmap and clears it at that clock edge. A wrap occurring on the same edge stays set.
- R9: Output irq is high exactly while some overflow bit has its interrupt-enable bit set. It falls in the cycle after the read that clears the overflow.
- R10: A counter write (0x20+i) stores all 32 bits, so writing 0xFFFFFFFF reads back 0xFFFFFFFF. A write wins over a same-cycle increment.
- R11: Addresses 0x06 and 0x07 return bits 31:0 and 63:32 of the AVAIL parameter, where bit n set means event code n is supported.
- R12: Writing 1 to control bit 1 zeroes all event counters, and writing 1 to control bit 2 zeroes the cycle counter. Both bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (needed for the clearing overflow read) |
| regAddr | input | 7 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| evtIn | input | EVT_LINES | Event pulse lines, one per event code |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The bench builds the block with NUM_CNT=5 and EVT_LINES=16. With these values, counter addresses and bitmap bits 5 to 30 are unimplemented and can be probed for R1. Event codes 16 to 19 fall beyond the wired lines, so the random rounds exercise the count-nothing case of R5. Random preloads near 0xFFFFFFFF drive wraps inside those rounds. Directed sequences line up a wrap with the clearing read on the same edge, and carry the 64-bit cycle counter across its full wrap.

// File: rtl/clu_pmon_pkg.sv
package clu_pmon_pkg;
  localparam logic [6:0] A_CTRL  = 7'h00;
  localparam logic [6:0] A_ENSET = 7'h01;
  localparam logic [6:0] A_ENCLR = 7'h02;
  localparam logic [6:0] A_IESET = 7'h03;
  localparam logic [6:0] A_IECLR = 7'h04;
  localparam logic [6:0] A_OVS   = 7'h05;
  localparam logic [6:0] A_AVLO  = 7'h06;
  localparam logic [6:0] A_AVHI  = 7'h07;
  localparam logic [6:0] A_CYCLO = 7'h08;
  localparam logic [6:0] A_CYCHI = 7'h09;
  localparam logic [1:0] RG_CNT  = 2'b01;  // 0x20..0x3F
  localparam logic [1:0] RG_TYPE = 2'b10;  // 0x40..0x5F
  localparam logic [7:0] CODE_CYCLES = 8'h11;
  localparam int CYC_BIT = 31;

  typedef struct packed {
    logic        ovsRead;
    logic        cntWr;
    logic        typeWr;
    logic [4:0]  idx;
    logic        cycWrLo;
    logic        cycWrHi;
    logic        zeroEvt;
    logic        zeroCyc;
    logic [31:0] data;
  } dpStrobe_t;
endpackage

// File: rtl/clu_pmon_ctrl.sv
module clu_pmon_ctrl
  import clu_pmon_pkg::*;
#(
  parameter int NUM_CNT = 6,
  parameter logic [7:0] ID = 8'h00,
  parameter logic [7:0] IMPL = 8'h00,
  parameter logic [63:0] AVAIL = 64'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regRe,
  input  logic [6:0]  regAddr,
  input  logic [31:0] regWdata,
  input  logic [31:0] cntVal [NUM_CNT],
  input  logic [7:0]  typeVal [NUM_CNT],
  input  logic [63:0] cycVal,
  input  logic [31:0] ovfBits,
  output dpStrobe_t   strobe,
  output logic        gEnable,
  output logic [31:0] enBits,
  output logic [31:0] ienBits,
  output logic [31:0] regRdata
);
  localparam logic [31:0] IMPL_MASK = 32'h8000_0000 | ((32'd1 << NUM_CNT) - 32'd1);
  localparam logic [4:0] NUM_FIELD = 5'(NUM_CNT);

  logic        idxOk;
  logic [31:0] wMask;

  assign idxOk = regAddr[4:0] < NUM_FIELD;
  assign wMask = regWdata & IMPL_MASK;

  always_comb begin
    strobe         = '0;
    strobe.data    = regWdata;
    strobe.idx     = regAddr[4:0];
    strobe.ovsRead = regRe && (regAddr == A_OVS);
    if (regWe) begin
      strobe.cntWr   = (regAddr[6:5] == RG_CNT) && idxOk;
      strobe.typeWr  = (regAddr[6:5] == RG_TYPE) && idxOk;
      strobe.cycWrLo = regAddr == A_CYCLO;
      strobe.cycWrHi = regAddr == A_CYCHI;
      strobe.zeroEvt = (regAddr == A_CTRL) && regWdata[1];
      strobe.zeroCyc = (regAddr == A_CTRL) && regWdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gEnable <= 1'b0;
      enBits  <= '0;
      ienBits <= '0;
    end else if (regWe) begin
      case (regAddr)
        A_CTRL:  gEnable <= regWdata[0];
        A_ENSET: enBits  <= enBits | wMask;
        A_ENCLR: enBits  <= enBits & ~wMask;
        A_IESET: ienBits <= ienBits | wMask;
        A_IECLR: ienBits <= ienBits & ~wMask;
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL:           regRdata = {IMPL, ID, NUM_FIELD, 10'b0, gEnable};
      A_ENSET, A_ENCLR: regRdata = enBits;
      A_IESET, A_IECLR: regRdata = ienBits;
      A_OVS:            regRdata = ovfBits;
      A_AVLO:           regRdata = AVAIL[31:0];
      A_AVHI:           regRdata = AVAIL[63:32];
      A_CYCLO:          regRdata = cycVal[31:0];
      A_CYCHI:          regRdata = cycVal[63:32];
      default: begin
        for (int i = 0; i < NUM_CNT; i++) begin
          if (regAddr[4:0] == 5'(i)) begin
            if (regAddr[6:5] == RG_CNT)  regRdata = cntVal[i];
            if (regAddr[6:5] == RG_TYPE) regRdata = {24'b0, typeVal[i]};
          end
        end
      end
    endcase
  end

  // R4: bits written through the set address are present on the next cycle
  p_enset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_ENSET) |=>
      ((enBits & ($past(regWdata) & IMPL_MASK)) == ($past(regWdata) & IMPL_MASK)));

  // R4: without a write the interrupt enables hold
  p_ien_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> (ienBits == $past(ienBits)));
endmodule

// File: rtl/clu_pmon_dp.sv
module clu_pmon_dp
  import clu_pmon_pkg::*;
#(
  parameter int NUM_CNT = 6,
  parameter int EVT_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic                 gEnable,
  input  logic [31:0]          enBits,
  input  logic [EVT_LINES-1:0] evtIn,
  output logic [31:0]          cntVal [NUM_CNT],
  output logic [7:0]           typeVal [NUM_CNT],
  output logic [63:0]          cycVal,
  output logic [31:0]          ovfBits
);
  localparam int SELW = (EVT_LINES > 1) ? $clog2(EVT_LINES) : 1;

  logic [NUM_CNT-1:0] evtWrap;
  logic [NUM_CNT-1:0] evtInc;
  logic               cycInc, cycWr, cycWrap;
  logic [31:0]        wrapVec;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hit, wrHere;
    assign wrHere = strobe.cntWr && (strobe.idx == 5'(i));
    always_comb begin
      if (typeVal[i] == CODE_CYCLES) hit = 1'b1;
      else if ({24'b0, typeVal[i]} < 32'(EVT_LINES)) hit = evtIn[typeVal[i][SELW-1:0]];
      else hit = 1'b0;
    end
    assign evtInc[i]  = gEnable && enBits[i] && hit;
    assign evtWrap[i] = evtInc[i] && (cntVal[i] == '1) && !wrHere && !strobe.zeroEvt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntVal[i]  <= '0;
        typeVal[i] <= '0;
      end else begin
        if (strobe.zeroEvt)  cntVal[i] <= '0;
        else if (wrHere)     cntVal[i] <= strobe.data;
        else if (evtInc[i])  cntVal[i] <= cntVal[i] + 32'd1;
        if (strobe.typeWr && strobe.idx == 5'(i)) typeVal[i] <= strobe.data[7:0];
      end
    end

    // R6: an increment from all-ones lands on zero with the overflow flagged
    p_wrap_sets_ovf_r6: assert property (@(posedge clk) disable iff (!rstN)
      (evtInc[i] && cntVal[i] == 32'hFFFF_FFFF && !wrHere && !strobe.zeroEvt) |=>
        (ovfBits[i] && cntVal[i] == 32'h0));
  end

  assign cycWr   = strobe.cycWrLo || strobe.cycWrHi || strobe.zeroCyc;
  assign cycInc  = gEnable && enBits[CYC_BIT];
  assign cycWrap = cycInc && !cycWr && (cycVal == '1);

  always_ff @(posedge clk) begin
    if (!rstN)                cycVal <= '0;
    else if (strobe.zeroCyc)  cycVal <= '0;
    else if (strobe.cycWrLo)  cycVal <= {cycVal[63:32], strobe.data};
    else if (strobe.cycWrHi)  cycVal <= {strobe.data, cycVal[31:0]};
    else if (cycInc)          cycVal <= cycVal + 64'd1;
  end

  always_comb begin
    wrapVec = '0;
    for (int i = 0; i < NUM_CNT; i++) wrapVec[i] = evtWrap[i];
    wrapVec[CYC_BIT] = cycWrap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ovfBits <= '0;
    else       ovfBits <= (strobe.ovsRead ? 32'h0 : ovfBits) | wrapVec;
  end

  // R2: with the global enable clear the cycle counter moves only by writes
  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!gEnable && !cycWr) |=> (cycVal == $past(cycVal)));

  // R7: an enabled cycle counter steps by exactly one
  p_cyc_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cycInc && !cycWr) |=> (cycVal == $past(cycVal) + 64'd1));

  // R8: the clearing read empties the status when nothing wraps alongside it
  p_ovs_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ovsRead && wrapVec == 32'h0) |=> (ovfBits == 32'h0));
endmodule

// File: rtl/clu_perf_mon.sv
module clu_perf_mon
  import clu_pmon_pkg::*;
#(
  parameter int NUM_CNT = 6,
  parameter int EVT_LINES = 32,
  parameter logic [7:0] ID = 8'h41,
  parameter logic [7:0] IMPL = 8'h07,
  parameter logic [63:0] AVAIL = 64'h0000_0000_3E02_0001
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic                 regRe,
  input  logic [6:0]           regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic [EVT_LINES-1:0] evtIn,
  output logic                 irq
);
  dpStrobe_t   strobe;
  logic        gEnable;
  logic [31:0] enBits, ienBits, ovfBits;
  logic [31:0] cntVal [NUM_CNT];
  logic [7:0]  typeVal [NUM_CNT];
  logic [63:0] cycVal;

  clu_pmon_ctrl #(.NUM_CNT(NUM_CNT), .ID(ID), .IMPL(IMPL), .AVAIL(AVAIL)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .cntVal(cntVal), .typeVal(typeVal), .cycVal(cycVal),
    .ovfBits(ovfBits), .strobe(strobe), .gEnable(gEnable), .enBits(enBits),
    .ienBits(ienBits), .regRdata(regRdata)
  );

  clu_pmon_dp #(.NUM_CNT(NUM_CNT), .EVT_LINES(EVT_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .gEnable(gEnable), .enBits(enBits),
    .evtIn(evtIn), .cntVal(cntVal), .typeVal(typeVal), .cycVal(cycVal),
    .ovfBits(ovfBits)
  );

  assign irq = |(ovfBits & ienBits);
endmodule

// File: tb/clu_perf_mon_tb.sv
module clu_perf_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 5;
  localparam int NL = 16;
  localparam logic [7:0] TB_ID = 8'h5A;
  localparam logic [7:0] TB_IMPL = 8'hC3;
  localparam logic [63:0] TB_AVAIL = 64'h0000_0001_3E0A_2F11;

  logic clk = 0, rstN = 0, regWe = 0, regRe = 0;
  logic [6:0] regAddr = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic [NL-1:0] evtIn = 0;
  logic irq;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clu_perf_mon #(.NUM_CNT(NC), .EVT_LINES(NL), .ID(TB_ID), .IMPL(TB_IMPL), .AVAIL(TB_AVAIL)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtIn(evtIn), .irq(irq));

  function automatic logic [31:0] ctrlExp(input logic g);
    return {TB_IMPL, TB_ID, 5'(NC), 10'b0, g};
  endfunction

  function automatic logic [31:0] implMask();
    return 32'h8000_0000 | ((32'd1 << NC) - 32'd1);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(posedge clk); #1 regWe = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); regRe = 1; regAddr = a;
    #1 d = regRdata;
    @(posedge clk); #1 regRe = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, v2;
    logic [31:0] mdl [NC];
    logic [7:0] typ [NC];
    logic [31:0] mOvf;
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1;

    // reset state
    rd(7'h00, v); chk("R3 reset ctrl", v, ctrlExp(0));
    rd(7'h01, v); chk("R1 reset enables", v, 0);
    rd(7'h05, v); chk("R8 reset overflow", v, 0);
    chk("R9 reset irq", irq, 0);

    // read-only control fields
    wr(7'h00, 32'hFFFF_FFF9);
    rd(7'h00, v); chk("R3 ro fields kept", v, ctrlExp(1));
    wr(7'h00, 0);
    rd(7'h00, v); chk("R2 global enable clears", v, ctrlExp(0));

    // bitmaps
    wr(7'h01, 32'hFFFF_FFFF);
    rd(7'h01, v); chk("R1 enable layout", v, implMask());
    wr(7'h02, 32'h0000_000A);
    rd(7'h02, v); chk("R4 clear ones", v, implMask() & ~32'hA);
    wr(7'h02, 32'h0);
    rd(7'h01, v); chk("R4 zero write no effect", v, implMask() & ~32'hA);
    wr(7'h02, 32'hFFFF_FFFF);
    rd(7'h01, v); chk("R4 clear all", v, 0);
    wr(7'h03, 32'h4000_0003);
    rd(7'h04, v); chk("R1 ien unimpl ignored", v, 32'h3);
    wr(7'h04, 32'hFFFF_FFFF);

    rd(7'h06, v); chk("R11 avail lo", v, TB_AVAIL[31:0]);
    rd(7'h07, v); chk("R11 avail hi", v, TB_AVAIL[63:32]);

    // counter write/read
    wr(7'h20, 32'hFFFF_FFFF);
    rd(7'h20, v); chk("R10 all ones readback", v, 32'hFFFF_FFFF);
    wr(7'h26, 32'h1234);
    rd(7'h26, v); chk("R1 unimpl counter reads 0", v, 0);
    wr(7'h08, 32'hDEAD_0001); wr(7'h09, 32'h0000_BEEF);
    rd(7'h08, v); chk("R7 cyc lo write", v, 32'hDEAD_0001);
    rd(7'h09, v); chk("R7 cyc hi write", v, 32'h0000_BEEF);

    // global enable off: nothing counts
    wr(7'h40, 32'h11); wr(7'h20, 5); wr(7'h01, 32'h8000_0001);
    repeat (10) @(posedge clk);
    rd(7'h20, v); chk("R2 event hold when off", v, 5);
    rd(7'h08, v); chk("R2 cyc hold when off", v, 32'hDEAD_0001);
    wr(7'h02, 32'h8000_0000);

    // code 0x11 counts every cycle
    wr(7'h00, 1);
    rd(7'h20, v); rd(7'h20, v2);
    chk("R5 cycles code step", v2 - v, 1);
    wr(7'h00, 0);

    // zeroing bits
    wr(7'h00, 2);
    rd(7'h20, v); chk("R12 event zero", v, 0);
    rd(7'h00, v); chk("R12 bits read 0", v, ctrlExp(0));
    wr(7'h00, 4);
    rd(7'h08, v); chk("R12 cyc zero lo", v, 0);
    rd(7'h09, v); chk("R12 cyc zero hi", v, 0);

    // wrap aligned with clearing read
    wr(7'h20, 32'hFFFF_FFFF);
    rd(7'h05, v);
    wr(7'h00, 1);
    rd(7'h05, v); chk("R8 read before wrap", v, 0);
    wr(7'h00, 0);
    rd(7'h05, v); chk("R8 same-edge wrap kept", v, 1);
    rd(7'h20, v); chk("R6 wrap then count", v, 1);
    rd(7'h05, v); chk("R8 cleared by read", v, 0);

    // write beats increment
    wr(7'h00, 1);
    wr(7'h20, 32'h0000_0100);
    wr(7'h00, 0);
    rd(7'h20, v); chk("R10 write wins", v, 32'h0000_0101);

    // interrupt
    wr(7'h03, 1);
    wr(7'h20, 32'hFFFF_FFFF);
    wr(7'h00, 1); wr(7'h00, 0);
    @(negedge clk); chk("R9 irq on overflow", irq, 1);
    rd(7'h05, v); chk("R6 overflow bit0", v, 1);
    chk("R9 irq falls after read", irq, 0);
    wr(7'h20, 32'hFFFF_FFFF);
    wr(7'h00, 1); wr(7'h00, 0);
    wr(7'h04, 1);
    @(negedge clk); chk("R9 masked irq", irq, 0);
    rd(7'h05, v); chk("R9 ovf pending while masked", v, 1);
    wr(7'h02, 1);

    // 64-bit cycle wrap
    wr(7'h01, 32'h8000_0000);
    wr(7'h09, 32'hFFFF_FFFF); wr(7'h08, 32'hFFFF_FFFD);
    wr(7'h00, 1);
    rd(7'h08, v); chk("R7 cyc first", v, 32'hFFFF_FFFD);
    rd(7'h08, v); chk("R7 cyc step", v, 32'hFFFF_FFFE);
    repeat (3) @(posedge clk);
    wr(7'h00, 0);
    rd(7'h08, v); chk("R7 cyc lo after wrap", v, 3);
    rd(7'h09, v); chk("R7 cyc hi after wrap", v, 0);
    rd(7'h05, v); chk("R7 cyc overflow bit31", v, 32'h8000_0000);
    wr(7'h02, 32'h8000_0000);

    // random rounds
    for (int r = 0; r < 3; r++) begin
      rd(7'h05, v);
      mOvf = 0;
      for (int i = 0; i < NC; i++) begin
        logic [7:0] c;
        c = 8'($urandom % 20);
        if (c == 8'h11) c = 8'h12;
        typ[i] = c;
        mdl[i] = ($urandom % 2) ? $urandom : (32'hFFFF_FF00 | ($urandom % 256));
        wr(7'(8'h40 + 8'(i)), {24'b0, c});
        wr(7'(8'h20 + 8'(i)), mdl[i]);
      end
      wr(7'h01, 32'h1F);
      wr(7'h00, 1);
      for (int k = 0; k < 150; k++) begin
        @(negedge clk);
        evtIn = 16'($urandom);
        for (int i = 0; i < NC; i++) begin
          if (typ[i] < 8'd16 && evtIn[typ[i][3:0]]) begin
            if (mdl[i] == 32'hFFFF_FFFF) mOvf[i] = 1'b1;
            mdl[i] = mdl[i] + 1;
          end
        end
      end
      @(negedge clk) evtIn = 0;
      wr(7'h00, 0);
      for (int i = 0; i < NC; i++) begin
        rd(7'(8'h20 + 8'(i)), v);
        chk($sformatf("R5 random count r%0d c%0d", r, i), v, mdl[i]);
      end
      rd(7'h05, v); chk("R6 random overflow", v, mOvf);
      wr(7'h02, 32'h1F);
    end

    done = 1;
    finish_run();
  end
endmodule